// File: doc/BRIEF.md
# Neighbour Signature Isolation Unit

Each node of a 2D mesh runs a self-test and ends up with a signature word. This unit sits beside the router of one node. It takes the local signature the first time its valid strobe is seen and sends it out on all four mesh links. It then judges each link on its own. A link stays enabled only when the neighbour's reply equals the local word on every bit. A link is cut when the reply differs, or when no reply arrives within a programmable window. No central controller takes part. Each node decides alone, so a faulty neighbour cannot undo the verdict from its side.

The result is a 4-bit link-enable mask for the router. All later traffic, route discovery included, treats a cleared link as absent. Links on the edge of the mesh are removed by a static tie-off input. A link that faces an I/O port is marked separately, bypasses the exchange and stays enabled. A cleared bit stays cleared until reset. A done flag tells the router when every link has a verdict.

Bit and slice order for all 4-wide vectors: index 0 = north, 1 = east, 2 = south, 3 = west. Link i of a packed signature bus occupies bits [i*SIG_W +: SIG_W].

Top module: `sig_iso_unit`

## Requirements
- R1: After reset, link_en_o is 4'b1111, done_o is 0 and tx_valid_o is 4'b0000.
- R2: The first cycle with local_sig_valid_i high captures local_sig_i. From the next cycle on, tx_sig_o carries that word in every slice, and tx_valid_o is high on each link i for which tie_off_i[i] is 0 or io_port_i[i] is 1. Later strobes are ignored.
- R3: A link whose neighbour signature equals the local one on all SIG_W bits keeps its link_en_o bit at 1.
- R4: A link whose neighbour signature differs from the local one in any bit has its link_en_o bit cleared.
- R5: Let the local signature be captured at clock edge k and let T be timeout_i. A link with no rx_valid_i sampled by edge k+T is cleared. A signature sampled at edge k+T is still accepted.
- R6: A link with tie_off_i=1 and io_port_i=0 is cleared without any exchange. A link with io_port_i=1 is kept enabled without any exchange, whatever its tie-off value.
- R7: A cleared link-enable bit never returns to 1 before reset. Signatures that arrive after a link has been resolved have no effect.
- R8: done_o rises once all four links are resolved, through comparison, timeout, tie-off or I/O marking. It then stays high until reset.
- R9: A neighbour signature that arrives before the local one is held and compared once the local signature is captured.
- R10: A timeout_i value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| local_sig_i | input | SIG_W | Local self-test signature |
| local_sig_valid_i | input | 1 | Strobe for local_sig_i |
| timeout_i | input | TO_W | Reply window in cycles after capture |
| tie_off_i | input | 4 | Static per-link mesh-edge tie-off |
| io_port_i | input | 4 | Link faces an I/O port (kept, no exchange) |
| rx_sig_i | input | 4*SIG_W | Signatures received from neighbours |
| rx_valid_i | input | 4 | Per-link strobe for rx_sig_i |
| tx_sig_o | output | 4*SIG_W | Local signature sent to each neighbour |
| tx_valid_o | output | 4 | Per-link send strobe |
| link_en_o | output | 4 | Link-enable mask for the router |
| done_o | output | 1 | All links resolved |

## Verification
Each link gets one of several reply patterns. An exact match, and a single-bit flip at any bit position, separate full equality from a partial compare. A reply at exactly edge T, and one a cycle later, separate an off-by-one error in the window. A reply sent before the local signature checks that early arrivals are held. No reply at all, and a matching reply after the verdict, check timeout and stickiness. Random tie-off and I/O markings, a zero timeout and a second local strobe cover the bypass paths and the capture-once rule.

// File: rtl/sig_iso_pkg.sv
package sig_iso_pkg;
  localparam int unsigned NUM_LINKS = 4;
  typedef enum logic [1:0] {LINK_N, LINK_E, LINK_S, LINK_W} link_e;
endpackage

// File: rtl/sig_iso_local.sv
module sig_iso_local #(
  parameter int unsigned SIG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             sig_valid_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             have_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_o <= 1'b0;
      sig_o  <= '0;
    end else if (sig_valid_i && !have_o) begin
      have_o <= 1'b1;
      sig_o  <= sig_i;
    end
  end
endmodule

// File: rtl/sig_iso_timer.sv
module sig_iso_timer #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] lim_m1;

  // zero window behaves as one cycle
  assign lim_m1   = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign expire_o = run_i && (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (run_i && (cnt_q != {TO_W{1'b1}}))
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sig_iso_judge.sv
module sig_iso_judge #(
  parameter int unsigned SIG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SIG_W-1:0] local_sig_i,
  input  logic             have_i,
  input  logic [SIG_W-1:0] rx_sig_i,
  input  logic             rx_valid_i,
  input  logic             tie_i,
  input  logic             io_i,
  input  logic             expire_i,
  output logic             en_o,
  output logic             resolved_o
);
  logic             got_q;
  logic [SIG_W-1:0] rx_q;

  // hold first reply, even if it precedes the local signature
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q <= 1'b0;
      rx_q  <= '0;
    end else if (rx_valid_i && !got_q && !resolved_o) begin
      got_q <= 1'b1;
      rx_q  <= rx_sig_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b1;
      resolved_o <= 1'b0;
    end else if (have_i && !resolved_o) begin
      if (io_i) begin
        resolved_o <= 1'b1;
      end else if (tie_i) begin
        resolved_o <= 1'b1;
        en_o       <= 1'b0;
      end else if (got_q) begin
        resolved_o <= 1'b1;
        if (rx_q != local_sig_i) en_o <= 1'b0;
      end else if (expire_i && !rx_valid_i) begin
        resolved_o <= 1'b1;
        en_o       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sig_iso_unit.sv
module sig_iso_unit #(
  parameter int unsigned SIG_W = 16,
  parameter int unsigned TO_W  = 8,
  localparam int unsigned NL   = sig_iso_pkg::NUM_LINKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIG_W-1:0]  local_sig_i,
  input  logic              local_sig_valid_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [NL-1:0]     tie_off_i,
  input  logic [NL-1:0]     io_port_i,
  input  logic [NL*SIG_W-1:0] rx_sig_i,
  input  logic [NL-1:0]     rx_valid_i,
  output logic [NL*SIG_W-1:0] tx_sig_o,
  output logic [NL-1:0]     tx_valid_o,
  output logic [NL-1:0]     link_en_o,
  output logic              done_o
);
  logic [SIG_W-1:0] sig_q;
  logic             have_q;
  logic             expire;
  logic [NL-1:0]    resolved;

  sig_iso_local #(.SIG_W(SIG_W)) u_local (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (local_sig_i),
    .sig_valid_i(local_sig_valid_i),
    .sig_o      (sig_q),
    .have_o     (have_q)
  );

  sig_iso_timer #(.TO_W(TO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (have_q && !done_o),
    .limit_i (timeout_i),
    .expire_o(expire)
  );

  for (genvar i = 0; i < NL; i++) begin : g_link
    sig_iso_judge #(.SIG_W(SIG_W)) u_judge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .local_sig_i(sig_q),
      .have_i     (have_q),
      .rx_sig_i   (rx_sig_i[i*SIG_W +: SIG_W]),
      .rx_valid_i (rx_valid_i[i]),
      .tie_i      (tie_off_i[i]),
      .io_i       (io_port_i[i]),
      .expire_i   (expire),
      .en_o       (link_en_o[i]),
      .resolved_o (resolved[i])
    );
    assign tx_sig_o[i*SIG_W +: SIG_W] = sig_q;
    assign tx_valid_o[i] = have_q && (io_port_i[i] || !tie_off_i[i]);
  end

  assign done_o = &resolved;
endmodule

// File: rtl/sig_iso_checker.sv
module sig_iso_checker #(
  parameter int unsigned SIG_W = 16,
  parameter int unsigned TO_W  = 8,
  localparam int unsigned NL   = sig_iso_pkg::NUM_LINKS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SIG_W-1:0]  local_sig_i,
  input logic              local_sig_valid_i,
  input logic [TO_W-1:0]   timeout_i,
  input logic [NL-1:0]     tie_off_i,
  input logic [NL-1:0]     io_port_i,
  input logic [NL*SIG_W-1:0] rx_sig_i,
  input logic [NL-1:0]     rx_valid_i,
  input logic [NL*SIG_W-1:0] tx_sig_o,
  input logic [NL-1:0]     tx_valid_o,
  input logic [NL-1:0]     link_en_o,
  input logic              done_o
);
  p_en_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((link_en_o & ~$past(link_en_o)) == '0));

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_tx_tied_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o & tie_off_i & ~io_port_i) == '0);

  p_tie_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((link_en_o & tie_off_i & ~io_port_i) == '0));

  p_io_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_o & io_port_i) == io_port_i);

  p_tx_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_valid_o) |=> $stable(tx_sig_o));
endmodule

bind sig_iso_unit sig_iso_checker #(.SIG_W(SIG_W), .TO_W(TO_W)) u_chk (.*);

// File: tb/tb_sig_iso_unit.sv
module tb_sig_iso_unit;
  localparam int SW = 16;
  localparam int TW = 8;
  localparam int NONE = 1000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [SW-1:0]   local_sig = '0;
  logic            local_vld = 1'b0;
  logic [TW-1:0]   tmo = '0;
  logic [3:0]      tie = '0;
  logic [3:0]      io = '0;
  logic [4*SW-1:0] rx_sig = '0;
  logic [3:0]      rx_vld = '0;
  logic [4*SW-1:0] tx_sig;
  logic [3:0]      tx_vld;
  logic [3:0]      link_en;
  logic            done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sig_iso_unit #(.SIG_W(SW), .TO_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .local_sig_i(local_sig), .local_sig_valid_i(local_vld),
    .timeout_i(tmo), .tie_off_i(tie), .io_port_i(io),
    .rx_sig_i(rx_sig), .rx_valid_i(rx_vld),
    .tx_sig_o(tx_sig), .tx_valid_o(tx_vld),
    .link_en_o(link_en), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic string cause(input int dl, input int teff, input bit t, input bit o,
                                  input bit eq);
    if (o || t) return "R6";
    if (dl == NONE) return "R5";
    if (dl > teff) return "R7";
    if (dl == teff) return "R5";
    if (dl == -1) return "R9";
    return eq ? "R3" : "R4";
  endfunction

  function automatic bit exp_en(input int dl, input int teff, input bit t, input bit o,
                                input bit eq);
    if (o) return 1'b1;
    if (t) return 1'b0;
    if (dl == NONE || dl > teff) return 1'b0;
    return eq;
  endfunction

  // dl: cycle index of reply relative to capture edge (0), -1 = before, NONE = never
  task automatic trial(input logic [SW-1:0] sig, input logic [3:0] t, input logic [3:0] o,
                       input logic [SW-1:0] rs [4], input int dl [4],
                       input logic [TW-1:0] tv, input bit extra);
    int teff;
    teff = (tv == 0) ? 1 : int'(tv);
    @(negedge clk);
    rst_n = 1'b0; tie = t; io = o; tmo = tv;
    local_vld = 1'b0; rx_vld = '0;
    for (int i = 0; i < 4; i++) rx_sig[i*SW +: SW] = rs[i];
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_en == 4'hF && !done && tx_vld == 4'h0, "R1", "reset state",
        {link_en, 3'b0, done, tx_vld}, {4'hF, 4'h0, 4'h0});
    for (int c = -1; c <= teff + 3; c++) begin
      local_vld = (c == 0) || (extra && c == 2);
      local_sig = (c == 0) ? sig : ~sig;
      for (int i = 0; i < 4; i++) rx_vld[i] = (dl[i] == c);
      @(negedge clk);
    end
    local_vld = 1'b0; rx_vld = '0;
    repeat (3) @(negedge clk);
    chk(tx_vld == ~(t & ~o), "R2", "tx_valid mask", tx_vld, ~(t & ~o));
    chk(tx_sig == {4{sig}}, "R2", "tx signature", tx_sig, {4{sig}});
    for (int i = 0; i < 4; i++) begin
      bit e;
      bit eq;
      eq = (rs[i] == sig);
      e = exp_en(dl[i], teff, t[i], o[i], eq);
      chk(link_en[i] == e, (tv == 0) ? "R10" : cause(dl[i], teff, t[i], o[i], eq),
          $sformatf("link %0d enable", i), link_en[i], e);
    end
    chk(done == 1'b1, "R8", "done", done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [SW-1:0] rs [4];
    int dl [4];
    logic [SW-1:0] s;
    void'($urandom(32'd1357));

    // directed: match at the last accepted edge (R5, R3)
    s = 16'hA5C3;
    for (int i = 0; i < 4; i++) begin rs[i] = s; dl[i] = 5; end
    trial(s, 4'h0, 4'h0, rs, dl, 8'd5, 1'b0);
    // one cycle late: all timed out, late match ignored (R5, R7)
    for (int i = 0; i < 4; i++) dl[i] = 6;
    trial(s, 4'h0, 4'h0, rs, dl, 8'd5, 1'b0);
    // zero timeout behaves as one (R10)
    dl[0] = 1; dl[1] = 2; dl[2] = 0; dl[3] = NONE;
    trial(s, 4'h0, 4'h0, rs, dl, 8'd0, 1'b0);
    // single-bit flips at LSB and MSB, early reply, second strobe (R4, R9, R2)
    rs[0] = s ^ 16'h0001; rs[1] = s ^ 16'h8000; rs[2] = s; rs[3] = s;
    dl[0] = 1; dl[1] = 0; dl[2] = -1; dl[3] = 3;
    trial(s, 4'h0, 4'h0, rs, dl, 8'd4, 1'b1);
    // tie-off and I/O bypass (R6)
    for (int i = 0; i < 4; i++) begin rs[i] = ~s; dl[i] = NONE; end
    trial(s, 4'b1011, 4'b0011, rs, dl, 8'd3, 1'b0);

    for (int n = 0; n < 150; n++) begin
      logic [TW-1:0] tv;
      int teff;
      s  = SW'($urandom);
      tv = TW'($urandom_range(0, 12));
      teff = (tv == 0) ? 1 : int'(tv);
      for (int i = 0; i < 4; i++) begin
        rs[i] = ($urandom_range(0, 1) == 1) ? s : s ^ (SW'(1) << $urandom_range(0, SW - 1));
        dl[i] = ($urandom_range(0, 5) == 0) ? NONE : $urandom_range(0, teff + 3) - 1;
      end
      trial(s, ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0,
            ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0, rs, dl, tv,
            $urandom_range(0, 1) == 1);
    end
    summary();
  end
endmodule